// File: doc/BRIEF.md
# Word-Clock Duty and Lock Supervisor

This block watches a frame-rate word clock from inside the master-clock domain that drives it. The master clock runs at a fixed multiple of the frame rate: 256 times when the ratio-select input is low, or 384 times when it is high. The relative phase of the two clocks is free. On every master-clock edge the block samples the word clock. It measures how many master-clock cycles the high half and the low half of each frame last. It then judges every complete frame against the selected ratio.

A frame fails when either half drifts from an even split by more than five percent of the ratio. It also fails when the whole frame misses the ratio by more than one cycle, or when the word clock stops changing. A failure produces a one-cycle resynchronisation pulse and restarts a converter initialisation window that lasts a fixed number of frames. The same window opens after power-up. While the window is open, the sample word passed through the block is forced to zero. Right after power-up, and again after each failure, the block lets a few frames go by before it judges any frame, so that a half-measured frame is never reported.

Top module: `wordclk_monitor`

## Requirements
- R1: With `ratio_sel` low the expected frame length is 256 master cycles. With `ratio_sel` high it is 384. A frame that is good at one ratio fails at the other.
- R2: Each half-frame (high phase, low phase) must last between ratio/2 − S and ratio/2 + S cycles, where S = ceil(5 % of ratio). That gives 115..141 at 256 and 172..212 at 384. A half outside this range fails the frame.
- R3: The sum of the two halves must lie within ratio ± 1. A sum of 257 is accepted and 258 fails.
- R4: While checking is armed, a single word-clock level held for ratio + 2 samples is a failure at that sample, with no wait for the next edge.
- R5: After reset and after every failure, the frames that end at the next three rising word-clock edges are not judged. The first two complete frames are therefore ignored. Judging resumes at the fourth rising edge.
- R6: A failure detected at the rising edge sampled on clock edge k makes `resync` high for exactly the cycle that follows edge k.
- R7: `init_busy` is high out of reset. It is set again by every failure. It clears after INIT_FRAMES rising word-clock edges with no failure in between. A failure reloads the full count.
- R8: `adc_out` is all zeros while `init_busy` is high. Otherwise it equals `adc_in`.
- R9: During reset, `resync` is 0, `init_busy` is 1 and `adc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| ratio_sel | input | 1 | Master/frame ratio: 0 selects 256, 1 selects 384 |
| lrck | input | 1 | Word clock; high half and low half form one frame, and a frame starts at a rising edge |
| adc_in | input | DW | Converter sample word to be gated |
| adc_out | output | DW | Gated sample word; zero during initialisation |
| init_busy | output | 1 | Initialisation window open |
| resync | output | 1 | One-cycle pulse on each detected failure |

## Verification
The bench probes both edges of the half-frame window (115/141 and 141/115 pass, 114/142 fails) and both edges of the frame-length slip (257 passes, 258 fails). A design with an off-by-one window would let a bad frame through or pulse on a good one. It holds the word clock still to show that the stall is caught after ratio + 2 samples. A block that waited for an edge would never recover. Right after a failure it feeds three more bad frames and expects a single pulse, which catches a warm-up counter that rearms too early or not at all. The run is repeated at the 384 ratio, where 256-length frames have to fail.

// File: rtl/wcm_pkg.sv
package wcm_pkg;

  // Allowed deviation of one half-frame, rounded up to whole cycles.
  function automatic int unsigned half_slack(int unsigned ratio, int unsigned pct);
    return (ratio * pct + 99) / 100;
  endfunction

  function automatic int unsigned half_floor(int unsigned ratio, int unsigned pct);
    return ratio / 2 - half_slack(ratio, pct);
  endfunction

  function automatic int unsigned half_ceil(int unsigned ratio, int unsigned pct);
    return ratio / 2 + half_slack(ratio, pct);
  endfunction

  // Sample count at which a held level counts as a stopped clock.
  function automatic int unsigned stall_limit(int unsigned ratio, int unsigned slip);
    return ratio + slip + 1;
  endfunction

endpackage

// File: rtl/wcm_phase_meter.sv
module wcm_phase_meter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrck,
  output logic          rise,
  output logic          fall,
  output logic [CW-1:0] run_len,
  output logic [CW-1:0] hi_len
);

  logic          lr_q;
  logic          level_change;
  logic [CW-1:0] run_q;
  logic [CW-1:0] hi_q;

  assign level_change = lrck ^ lr_q;
  assign rise         = lrck & ~lr_q;
  assign fall         = ~lrck & lr_q;
  assign run_len      = run_q;
  assign hi_len       = hi_q;

  // run_q counts samples of the level currently held; saturates at all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q  <= 1'b0;
      run_q <= '0;
      hi_q  <= '0;
    end else begin
      lr_q <= lrck;
      if (level_change) begin
        run_q <= CW'(1);
      end else if (run_q != '1) begin
        run_q <= run_q + CW'(1);
      end
      if (fall) begin
        hi_q <= run_q;
      end
    end
  end

  p_run_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> (run_len == CW'(1)));

endmodule

// File: rtl/wcm_frame_judge.sv
module wcm_frame_judge
  import wcm_pkg::*;
#(
  parameter int unsigned RATIO_LO    = 256,
  parameter int unsigned RATIO_HI    = 384,
  parameter int unsigned DUTY_PCT    = 5,
  parameter int unsigned SLIP        = 1,
  parameter int unsigned WARM_FRAMES = 2,
  parameter int          CW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ratio_sel,
  input  logic          rise,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] run_len,
  output logic          fault,
  output logic          armed
);

  localparam int unsigned ARM_AT = WARM_FRAMES + 1;
  localparam int          WW     = $clog2(ARM_AT + 1);

  int unsigned   ratio;
  logic [CW-1:0] half_min;
  logic [CW-1:0] half_max;
  logic [CW-1:0] stall_at;
  logic [CW:0]   tot;
  logic [CW:0]   tot_min;
  logic [CW:0]   tot_max;
  logic          hi_ok;
  logic          lo_ok;
  logic          tot_ok;
  logic          frame_bad;
  logic          stall_hit;
  logic [WW-1:0] warm_q;

  always_comb begin
    ratio     = ratio_sel ? RATIO_HI : RATIO_LO;
    half_min  = CW'(half_floor(ratio, DUTY_PCT));
    half_max  = CW'(half_ceil(ratio, DUTY_PCT));
    stall_at  = CW'(stall_limit(ratio, SLIP));
    tot_min   = (CW+1)'(ratio - SLIP);
    tot_max   = (CW+1)'(ratio + SLIP);
    tot       = {1'b0, hi_len} + {1'b0, run_len};
    hi_ok     = (hi_len >= half_min) && (hi_len <= half_max);
    lo_ok     = (run_len >= half_min) && (run_len <= half_max);
    tot_ok    = (tot >= tot_min) && (tot <= tot_max);
    frame_bad = !(hi_ok && lo_ok && tot_ok);
    stall_hit = (run_len == stall_at);
  end

  assign armed = (warm_q == WW'(ARM_AT));
  assign fault = armed && ((rise && frame_bad) || stall_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (fault) begin
      warm_q <= '0;
    end else if (rise && !armed) begin
      warm_q <= warm_q + WW'(1);
    end
  end

  p_stall_caught_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (run_len <= stall_at));

  p_arm_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(rise));

endmodule

// File: rtl/wcm_init_seq.sv
module wcm_init_seq #(
  parameter int unsigned INIT_FRAMES = 516,
  parameter int          DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fault,
  input  logic [DW-1:0] adc_in,
  output logic [DW-1:0] adc_out,
  output logic          init_busy,
  output logic          resync
);

  localparam int IW = $clog2(INIT_FRAMES + 1);

  logic [IW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= IW'(INIT_FRAMES);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fault;
      if (fault) begin
        left_q <= IW'(INIT_FRAMES);
      end else if (rise && (left_q != '0)) begin
        left_q <= left_q - IW'(1);
      end
    end
  end

  assign init_busy = (left_q != '0);
  assign resync    = pulse_q;
  assign adc_out   = init_busy ? '0 : adc_in;

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  p_busy_on_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> init_busy);

  p_busy_ends_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> $past(rise));

endmodule

// File: rtl/wordclk_monitor.sv
module wordclk_monitor #(
  parameter int unsigned RATIO_LO    = 256,
  parameter int unsigned RATIO_HI    = 384,
  parameter int unsigned DUTY_PCT    = 5,
  parameter int unsigned SLIP        = 1,
  parameter int unsigned WARM_FRAMES = 2,
  parameter int unsigned INIT_FRAMES = 516,
  parameter int          DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ratio_sel,
  input  logic          lrck,
  input  logic [DW-1:0] adc_in,
  output logic [DW-1:0] adc_out,
  output logic          init_busy,
  output logic          resync
);

  localparam int CW = $clog2(2 * RATIO_HI + 4);

  logic          rise;
  logic          fall;
  logic [CW-1:0] run_len;
  logic [CW-1:0] hi_len;
  logic          fault;
  logic          armed;

  wcm_phase_meter #(.CW(CW)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .lrck    (lrck),
    .rise    (rise),
    .fall    (fall),
    .run_len (run_len),
    .hi_len  (hi_len)
  );

  wcm_frame_judge #(
    .RATIO_LO    (RATIO_LO),
    .RATIO_HI    (RATIO_HI),
    .DUTY_PCT    (DUTY_PCT),
    .SLIP        (SLIP),
    .WARM_FRAMES (WARM_FRAMES),
    .CW          (CW)
  ) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .rise      (rise),
    .hi_len    (hi_len),
    .run_len   (run_len),
    .fault     (fault),
    .armed     (armed)
  );

  wcm_init_seq #(
    .INIT_FRAMES (INIT_FRAMES),
    .DW          (DW)
  ) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .fault     (fault),
    .adc_in    (adc_in),
    .adc_out   (adc_out),
    .init_busy (init_busy),
    .resync    (resync)
  );

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !armed);

  p_no_fall_during_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

endmodule

// File: tb/wordclk_monitor_bench.sv
`timescale 1ns/1ps
module wordclk_monitor_bench;

  localparam int INIT_N = 4;
  localparam int DW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ratio_sel = 1'b0;
  logic          lrck = 1'b0;
  logic [DW-1:0] adc_in = '0;
  logic [DW-1:0] adc_out;
  logic          init_busy;
  logic          resync;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  int  m_prev = 0, m_run = 0, m_hi = 0, m_warm = 0, m_left = INIT_N;
  bit  m_pulse = 0;

  always #2 clk = ~clk;

  wordclk_monitor #(.INIT_FRAMES(INIT_N), .DW(DW)) u_wordclk_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .lrck      (lrck),
    .adc_in    (adc_in),
    .adc_out   (adc_out),
    .init_busy (init_busy),
    .resync    (resync)
  );

  // Behavioural model of the requirements, advanced on each rising edge.
  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_prev = 0; m_run = 0; m_hi = 0; m_warm = 0; m_left = INIT_N; m_pulse = 0;
    end else begin
      int s, ratio, slack, lo_b, hi_b;
      bit up, bad;
      s     = lrck ? 1 : 0;
      ratio = ratio_sel ? 384 : 256;
      slack = (ratio * 5 + 99) / 100;
      lo_b  = ratio / 2 - slack;
      hi_b  = ratio / 2 + slack;
      up    = (s == 1) && (m_prev == 0);
      bad   = 0;
      if (m_warm >= 3) begin
        if (up && (m_hi < lo_b || m_hi > hi_b || m_run < lo_b || m_run > hi_b ||
                   m_hi + m_run < ratio - 1 || m_hi + m_run > ratio + 1)) bad = 1;
        if (m_run == ratio + 2) bad = 1;
      end
      if (bad) begin
        m_warm = 0; m_left = INIT_N;
      end else if (up) begin
        if (m_warm < 3) m_warm++;
        if (m_left > 0) m_left--;
      end
      if (s != m_prev) begin
        if (s == 0) m_hi = m_run;
        m_run = 1;
      end else if (m_run < 1023) begin
        m_run++;
      end
      m_prev  = s;
      m_pulse = bad;
    end
  end

  // Compare on every falling edge and drive a fresh sample word.
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (resync !== m_pulse) begin
        errors++;
        $display("FAIL R6 resync got %0b exp %0b at %0t", resync, m_pulse, $time);
      end
      checks++;
      if (init_busy !== (m_left != 0)) begin
        errors++;
        $display("FAIL R7 init_busy got %0b exp %0b at %0t", init_busy, (m_left != 0), $time);
      end
      checks++;
      if (adc_out !== ((m_left != 0) ? '0 : adc_in)) begin
        errors++;
        $display("FAIL R8 adc_out got %h exp %h at %0t", adc_out,
                 (m_left != 0) ? 16'h0 : adc_in, $time);
      end
      if (resync === 1'b1) pulses++;
    end
    adc_in <= adc_in + 16'h1357;
  end

  task automatic frames(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      lrck = 1'b1;
      repeat (h) @(negedge clk);
      lrck = 1'b0;
      repeat (l) @(negedge clk);
    end
  endtask

  task automatic expect_pulses(input string tag, input int exp);
    checks++;
    if (pulses != exp) begin
      errors++;
      $display("FAIL %s pulse count got %0d exp %0d", tag, pulses, exp);
    end
    pulses = 0;
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n = 1'b0;
    ratio_sel = sel;
    lrck = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (resync !== 1'b0 || init_busy !== 1'b1 || adc_out !== '0) begin
      errors++;
      $display("FAIL R9 reset state got %0b/%0b/%h exp 0/1/0000", resync, init_busy, adc_out);
    end
    rst_n = 1'b1;
    pulses = 0;
  endtask

  initial begin
    do_reset(1'b0);
    // R1/R2: nominal 256 frames, then the window edges
    frames(128, 128, 8);
    checks++;
    if (init_busy !== 1'b0 || adc_out !== adc_in) begin
      errors++;
      $display("FAIL R7 window still open got %0b exp 0", init_busy);
    end
    frames(115, 141, 3);
    frames(141, 115, 3);
    frames(128, 128, 1);
    expect_pulses("R2 legal edges", 0);
    // R2: one half just outside
    frames(114, 142, 1);
    frames(128, 128, 6);
    expect_pulses("R2 outside", 1);
    // R3: slip of one accepted, two rejected
    frames(129, 128, 3);
    frames(128, 128, 1);
    expect_pulses("R3 slip one", 0);
    frames(130, 128, 1);
    frames(128, 128, 6);
    expect_pulses("R3 slip two", 1);
    // R4: word clock stops high
    lrck = 1'b1;
    repeat (300) @(negedge clk);
    frames(128, 128, 6);
    expect_pulses("R4 stall", 1);
    // R5: bad frames right after a failure are not judged
    frames(100, 156, 4);
    frames(128, 128, 6);
    expect_pulses("R5 warm-up", 1);

    // R1: 384 ratio
    do_reset(1'b1);
    frames(192, 192, 8);
    frames(172, 212, 2);
    frames(212, 172, 2);
    frames(192, 192, 1);
    expect_pulses("R1 ratio 384 legal", 0);
    frames(171, 213, 1);
    frames(192, 192, 6);
    expect_pulses("R2 ratio 384 outside", 1);
    frames(128, 128, 2);
    frames(192, 192, 6);
    expect_pulses("R1 short frames at 384", 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule